// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a processor register port and the serial shift engine of a SPI master. It contains two byte FIFOs: a transmit FIFO that the processor fills and the shift engine drains, and a receive FIFO that the shift engine fills and the processor drains. The processor reaches both FIFOs through 32-bit port registers. Word accesses move four bytes in big-endian order. Byte accesses move one byte, so a transfer whose length is not a multiple of four can be finished.

The block also holds the status and configuration registers that go with the FIFOs:

- A global mode word carrying enable, loopback and two FIFO thresholds.
- A command word.
- One mode word per chip select.
- An event register that shows live FIFO byte counts, live "receive not empty" and "transmit not full" flags, and sticky overflow and underflow flags.
- A mask register that selects which event bits drive the single interrupt line.

The shift engine uses a one-byte pop handshake on the transmit side and a one-byte push handshake on the receive side. Both handshakes are frozen while the global enable is low.

Register reads are combinational. `reg_rdata` is valid in the cycle `reg_rd` is high. Writes and FIFO pops take effect at the next rising edge.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: After reset, the mode register reads 0x0000_0403, the event register reads 0x0000_0100, the mask register reads 0 and `irq` is low.
- R2: In the mode register at offset 0x000:
  - bit 31 is the global enable and bit 30 is loopback; both appear on `cfg_enable` and `cfg_loop`.
  - bits 13:8 hold the transmit threshold and bits 5:0 the receive threshold.
  - all other bits read as 0.
- R3: Event register bits 29:24 hold the current receive FIFO byte count and bits 21:16 hold the transmit FIFO byte count. The event register is at offset 0x004.
- R4: Event bit 9 is 1 exactly when the receive FIFO holds at least one byte. Event bit 8 is 1 exactly when the transmit FIFO holds fewer than 32 bytes.
- R5: Writes to the transmit port at offset 0x010:
  - A word write pushes four bytes, and the byte in bits 31:24 leaves first on `tx_byte`.
  - A byte write (`reg_byte`=1) pushes the single byte in bits 7:0.
- R6: Reads from the receive port at offset 0x014:
  - A word read returns the four oldest bytes, oldest in bits 31:24, and removes them.
  - A byte read returns the oldest byte in bits 7:0 and removes it.
- R7: A transmit port write that does not fit in the free space leaves the FIFO unchanged and sets sticky event bit 0. A word needs 4 free bytes and a byte needs 1.
- R8: A receive port read that asks for more bytes than are stored returns 0, removes nothing and sets sticky event bit 1.
- R9: Writing the event register clears each sticky bit (1 and 0) whose written bit is 1. Written zeros, and all other written bits, change nothing.
- R10: `irq` is the OR of event bits 9, 8, 1 and 0, each ANDed with the mask register bit at the same position. The mask is at offset 0x008, and only those four mask bits are stored; the others read 0.
- R11: While the enable is 0:
  - `tx_avail` and `rx_room` are low, and shift-engine pushes and pops are ignored.
  - FIFO contents and all configuration are kept, and transfers resume when the enable returns to 1.
- R12: The command register at 0x00C and the per-chip-select mode registers at 0x020 + 4*n store all 32 bits. They read back and appear on `cfg_cmd` and `cfg_csmode` (chip select n in bits 32n+31:32n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (receive port pops on the edge) |
| reg_byte | input | 1 | 1 = byte-wide access on the FIFO ports, 0 = word |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| tx_pop | input | 1 | Shift engine takes one transmit byte |
| tx_avail | output | 1 | A transmit byte is available and the unit is enabled |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shift engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive FIFO has space and the unit is enabled |
| cfg_enable | output | 1 | Global enable |
| cfg_loop | output | 1 | Loopback select |
| cfg_tx_thr | output | 6 | Transmit threshold |
| cfg_rx_thr | output | 6 | Receive threshold |
| cfg_cmd | output | 32 | Command word |
| cfg_csmode | output | NUM_CS*32 | Per-chip-select mode words |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a nearly full transmit FIFO, where a word write must be refused while a byte write still fits. The stimulus fills the FIFO with eight word writes and drains exactly two bytes through the shift-engine handshake. It then shows that a word write is rejected with the overflow flag set, while a single byte write is accepted. The receive side gets the mirror case: a word read against two stored bytes must return zero and leave both bytes in place, and byte reads then drain them.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
   localparam logic [7:0] OFF_MODE = 8'h00;
   localparam logic [7:0] OFF_EVT  = 8'h04;
   localparam logic [7:0] OFF_MASK = 8'h08;
   localparam logic [7:0] OFF_CMD  = 8'h0C;
   localparam logic [7:0] OFF_TXP  = 8'h10;
   localparam logic [7:0] OFF_RXP  = 8'h14;
   localparam logic [7:0] OFF_CS0  = 8'h20;

   localparam int THR_W = 6;
   localparam int CNT_W = 6;

   localparam int EV_RXNE = 9;
   localparam int EV_TXNF = 8;
   localparam int EV_UNF  = 1;
   localparam int EV_OVF  = 0;
   localparam int EV_RXC_LSB = 24;
   localparam int EV_TXC_LSB = 16;

   typedef struct packed {
      logic             en;
      logic             loop;
      logic [THR_W-1:0] tx_thr;
      logic [THR_W-1:0] rx_thr;
   } mode_t;
endpackage

// File: rtl/spi_evt_fifo.sv
module spi_evt_fifo #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       push_n,
   input  logic [31:0]      push_data,
   input  logic [2:0]       pop_n,
   output logic [31:0]      head,
   output logic [CNT_W-1:0] count
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 4 || DEPTH > (1 << CNT_W) - 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_evt_fifo: DEPTH must be a power of two, at least 4, and fit in CNT_W");
   end

   logic [7:0]       mem_q [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (i < int'(push_n))
            mem_q[wptr_q + PTR_W'(i)] <= push_data[31-8*i -: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         wptr_q <= wptr_q + PTR_W'(push_n);
         rptr_q <= rptr_q + PTR_W'(pop_n);
         cnt_q  <= cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_head
      assign head[31-8*g -: 8] = mem_q[rptr_q + PTR_W'(g)];
   end

   assign count = cnt_q;

   assert_fifo_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_n != 3'd0) |-> (int'(cnt_q) + int'(push_n) <= DEPTH));
   assert_fifo_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_n != 3'd0) |-> (int'(pop_n) <= int'(cnt_q)));
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH);
endmodule

// File: rtl/spi_evt_cfg.sv
module spi_evt_cfg
   import spi_evt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_CS     = 4,
   parameter int TX_THR_RST = 4,
   parameter int RX_THR_RST = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output mode_t               mode,
   output logic [31:0]         cmd,
   output logic [NUM_CS*32-1:0] csmode
);
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("spi_evt_cfg: NUM_CS must be 1..4");
   end

   mode_t       mode_q;
   logic [31:0] cmd_q;
   logic        mode_wr;

   assign mode_wr = wr_en && (addr == ADDR_W'(OFF_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '{en: 1'b0, loop: 1'b0,
                     tx_thr: THR_W'(TX_THR_RST), rx_thr: THR_W'(RX_THR_RST)};
         cmd_q  <= '0;
      end else begin
         if (mode_wr)
            mode_q <= '{en: wdata[31], loop: wdata[30],
                        tx_thr: wdata[8 +: THR_W], rx_thr: wdata[0 +: THR_W]};
         if (wr_en && addr == ADDR_W'(OFF_CMD))
            cmd_q <= wdata;
      end
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      logic [31:0] cs_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cs_q <= '0;
         else if (wr_en && addr == ADDR_W'(OFF_CS0) + ADDR_W'(4*g))
            cs_q <= wdata;
      end
      assign csmode[32*g +: 32] = cs_q;
   end

   assign mode = mode_q;
   assign cmd  = cmd_q;

   assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode_q));
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_ovf,
   input  logic       set_unf,
   input  logic       clr_wr,
   input  logic [1:0] clr_bits,
   input  logic       mask_wr,
   input  logic [3:0] mask_wdata,
   input  logic       live_ne,
   input  logic       live_nf,
   output logic [1:0] sticky,
   output logic [3:0] mask,
   output logic       irq
);
   logic [1:0] sticky_q;
   logic [3:0] mask_q;
   logic [1:0] clr_eff;

   assign clr_eff = clr_wr ? clr_bits : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         mask_q   <= '0;
      end else begin
         sticky_q[0] <= set_ovf | (sticky_q[0] & ~clr_eff[0]);
         sticky_q[1] <= set_unf | (sticky_q[1] & ~clr_eff[1]);
         if (mask_wr)
            mask_q <= mask_wdata;
      end
   end

   assign irq    = |({live_ne, live_nf, sticky_q} & mask_q);
   assign sticky = sticky_q;
   assign mask   = mask_q;

   assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[0] && !clr_eff[0]) |=> sticky_q[0]);
   assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != 4'd0));
endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
   import spi_evt_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int NUM_CS     = 4,
   parameter int ADDR_W     = 8,
   parameter int TX_THR_RST = 4,
   parameter int RX_THR_RST = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic                 reg_byte,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 tx_pop,
   output logic                 tx_avail,
   output logic [7:0]           tx_byte,
   input  logic                 rx_push,
   input  logic [7:0]           rx_byte,
   output logic                 rx_room,
   output logic                 cfg_enable,
   output logic                 cfg_loop,
   output logic [THR_W-1:0]     cfg_tx_thr,
   output logic [THR_W-1:0]     cfg_rx_thr,
   output logic [31:0]          cfg_cmd,
   output logic [NUM_CS*32-1:0] cfg_csmode,
   output logic                 irq
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_fifo_evt_unit: ADDR_W must cover offsets up to 0x2C");
   end

   mode_t            mode;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic [31:0]      tx_head, rx_head, tx_in;
   logic [2:0]       need_n, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic             cpu_tx_req, cpu_rx_req, tx_fit, rx_have;
   logic [1:0]       sticky;
   logic [3:0]       mask;
   logic             live_ne, live_nf;

   assign need_n     = reg_byte ? 3'd1 : 3'd4;
   assign cpu_tx_req = reg_wr && reg_addr == ADDR_W'(OFF_TXP);
   assign cpu_rx_req = reg_rd && reg_addr == ADDR_W'(OFF_RXP);
   assign tx_fit     = int'(tx_cnt) + int'(need_n) <= DEPTH;
   assign rx_have    = int'(rx_cnt) >= int'(need_n);

   assign tx_in     = reg_byte ? {reg_wdata[7:0], 24'h0} : reg_wdata;
   assign tx_push_n = (cpu_tx_req && tx_fit) ? need_n : 3'd0;
   assign tx_avail  = mode.en && tx_cnt != '0;
   assign tx_pop_n  = (tx_pop && tx_avail) ? 3'd1 : 3'd0;
   assign tx_byte   = tx_head[31:24];

   assign rx_room   = mode.en && int'(rx_cnt) != DEPTH;
   assign rx_push_n = (rx_push && rx_room) ? 3'd1 : 3'd0;
   assign rx_pop_n  = (cpu_rx_req && rx_have) ? need_n : 3'd0;

   assign live_ne = rx_cnt != '0;
   assign live_nf = int'(tx_cnt) != DEPTH;

   spi_evt_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_data(tx_in),
      .pop_n(tx_pop_n), .head(tx_head), .count(tx_cnt));

   spi_evt_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_data({rx_byte, 24'h0}),
      .pop_n(rx_pop_n), .head(rx_head), .count(rx_cnt));

   spi_evt_cfg #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS),
                 .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .mode(mode), .cmd(cfg_cmd), .csmode(cfg_csmode));

   spi_evt_irq u_evt (
      .clk(clk), .rst_n(rst_n),
      .set_ovf(cpu_tx_req && !tx_fit), .set_unf(cpu_rx_req && !rx_have),
      .clr_wr(reg_wr && reg_addr == ADDR_W'(OFF_EVT)), .clr_bits(reg_wdata[1:0]),
      .mask_wr(reg_wr && reg_addr == ADDR_W'(OFF_MASK)),
      .mask_wdata({reg_wdata[EV_RXNE], reg_wdata[EV_TXNF], reg_wdata[EV_UNF], reg_wdata[EV_OVF]}),
      .live_ne(live_ne), .live_nf(live_nf), .sticky(sticky), .mask(mask), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_addr)
            ADDR_W'(OFF_MODE): begin
               reg_rdata[31]         = mode.en;
               reg_rdata[30]         = mode.loop;
               reg_rdata[8 +: THR_W] = mode.tx_thr;
               reg_rdata[0 +: THR_W] = mode.rx_thr;
            end
            ADDR_W'(OFF_EVT): begin
               reg_rdata[EV_RXC_LSB +: CNT_W] = rx_cnt;
               reg_rdata[EV_TXC_LSB +: CNT_W] = tx_cnt;
               reg_rdata[EV_RXNE] = live_ne;
               reg_rdata[EV_TXNF] = live_nf;
               reg_rdata[EV_UNF]  = sticky[1];
               reg_rdata[EV_OVF]  = sticky[0];
            end
            ADDR_W'(OFF_MASK): begin
               reg_rdata[EV_RXNE] = mask[3];
               reg_rdata[EV_TXNF] = mask[2];
               reg_rdata[EV_UNF]  = mask[1];
               reg_rdata[EV_OVF]  = mask[0];
            end
            ADDR_W'(OFF_CMD): reg_rdata = cfg_cmd;
            ADDR_W'(OFF_RXP): begin
               if (rx_have)
                  reg_rdata = reg_byte ? {24'h0, rx_head[31:24]} : rx_head;
            end
            default: begin
               for (int c = 0; c < NUM_CS; c++) begin
                  if (reg_addr == ADDR_W'(OFF_CS0) + ADDR_W'(4*c))
                     reg_rdata = cfg_csmode[32*c +: 32];
               end
            end
         endcase
      end
   end

   assign cfg_enable = mode.en;
   assign cfg_loop   = mode.loop;
   assign cfg_tx_thr = mode.tx_thr;
   assign cfg_rx_thr = mode.rx_thr;

   assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.en && rx_pop_n == 3'd0) |=> $stable(rx_cnt));
   assert_ovf_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_tx_req && int'(tx_cnt) == DEPTH) |=> sticky[0]);
endmodule

// File: tb/sim_spi_fifo_evt_unit.sv
`timescale 1ns/1ps
module sim_spi_fifo_evt_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0, reg_rd = 1'b0, reg_byte = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         tx_pop = 1'b0, tx_avail;
   logic [7:0]   tx_byte;
   logic         rx_push = 1'b0, rx_room;
   logic [7:0]   rx_byte = '0;
   logic         cfg_enable, cfg_loop;
   logic [5:0]   cfg_tx_thr, cfg_rx_thr;
   logic [31:0]  cfg_cmd;
   logic [127:0] cfg_csmode;
   logic         irq;

   int runs = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   spi_fifo_evt_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_byte(reg_byte),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_byte(tx_byte),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room),
      .cfg_enable(cfg_enable), .cfg_loop(cfg_loop), .cfg_tx_thr(cfg_tx_thr),
      .cfg_rx_thr(cfg_rx_thr), .cfg_cmd(cfg_cmd), .cfg_csmode(cfg_csmode), .irq(irq));

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      runs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %08h expected %08h", what, got, exp);
      end
   endtask

   function automatic logic [31:0] ev(input int rxc, input int txc, input bit u, input bit o);
      return {2'b0, 6'(rxc), 2'b0, 6'(txc), 6'b0, 1'(rxc != 0), 1'(txc != 32), 6'b0, u, o};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit b);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_byte = b;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_byte = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input bit b, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a; reg_byte = b;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0; reg_byte = 1'b0;
   endtask

   task automatic eng_pop(output logic [7:0] d);
      @(negedge clk);
      tx_pop = 1'b1;
      #1 d = tx_byte;
      @(posedge clk); #1;
      tx_pop = 1'b0;
   endtask

   task automatic eng_push(input logic [7:0] d);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = d;
      @(posedge clk); #1;
      rx_push = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(8'h00, 0, d); chk("R1 mode reset", d, 32'h0000_0403);
      rd(8'h04, 0, d); chk("R1 event reset", d, 32'h0000_0100);
      rd(8'h08, 0, d); chk("R1 mask reset", d, 32'h0);
      chk("R1 irq reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mode;
      logic [31:0] d;
      wr(8'h00, 32'hFFFF_FFFF, 0);
      rd(8'h00, 0, d); chk("R2 mode readback", d, 32'hC000_3F3F);
      chk("R2 enable/loop/thr pins", {18'b0, cfg_enable, cfg_loop, cfg_tx_thr, cfg_rx_thr},
          {18'b0, 1'b1, 1'b1, 6'h3F, 6'h3F});
      wr(8'h00, 32'h8000_0403, 0);
      chk("R2 loop off", {30'b0, cfg_enable, cfg_loop}, 32'h2);
   endtask

   task automatic t_tx;
      logic [31:0] d;
      logic [7:0]  b;
      logic [7:0]  exp [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      wr(8'h10, 32'h1122_3344, 0);
      rd(8'h04, 0, d); chk("R3 tx count after word", d, ev(0, 4, 0, 0));
      wr(8'h10, 32'hFFFF_FF55, 1);
      rd(8'h04, 0, d); chk("R3 tx count after byte", d, ev(0, 5, 0, 0));
      for (int i = 0; i < 5; i++) begin
         eng_pop(b); chk("R5 tx wire order", {24'b0, b}, {24'b0, exp[i]});
      end
      rd(8'h04, 0, d); chk("R3 tx drained", d, ev(0, 0, 0, 0));
   endtask

   task automatic t_rx;
      logic [31:0] d;
      for (int i = 1; i <= 5; i++) eng_push(8'hA0 + 8'(i));
      rd(8'h04, 0, d); chk("R4 rx count and not-empty", d, ev(5, 0, 0, 0));
      rd(8'h14, 0, d); chk("R6 word pop", d, 32'hA1A2_A3A4);
      rd(8'h04, 0, d); chk("R3 rx count after word pop", d, ev(1, 0, 0, 0));
      rd(8'h14, 1, d); chk("R6 byte pop", d, 32'h0000_00A5);
      rd(8'h04, 0, d); chk("R4 rx empty", d, ev(0, 0, 0, 0));
   endtask

   task automatic t_under;
      logic [31:0] d;
      rd(8'h14, 0, d); chk("R8 empty word pop data", d, 32'h0);
      rd(8'h04, 0, d); chk("R8 underflow flag", d, ev(0, 0, 1, 0));
      eng_push(8'hB1); eng_push(8'hB2);
      rd(8'h14, 0, d); chk("R8 short word pop data", d, 32'h0);
      rd(8'h04, 0, d); chk("R8 short pop keeps bytes", d, ev(2, 0, 1, 0));
      rd(8'h14, 1, d); chk("R6 trailing byte 1", d, 32'h0000_00B1);
      rd(8'h14, 1, d); chk("R6 trailing byte 2", d, 32'h0000_00B2);
   endtask

   task automatic t_over;
      logic [31:0] d;
      logic [7:0]  b;
      for (int i = 0; i < 8; i++) wr(8'h10, 32'h0101_0101 * 32'(i), 0);
      rd(8'h04, 0, d); chk("R4 tx full clears not-full", d, ev(0, 32, 1, 0));
      wr(8'h10, 32'hDEAD_BEEF, 0);
      rd(8'h04, 0, d); chk("R7 overflow on full", d, ev(0, 32, 1, 1));
      eng_pop(b); eng_pop(b);
      wr(8'h10, 32'hDEAD_BEEF, 0);
      rd(8'h04, 0, d); chk("R7 word refused with 2 free", d, ev(0, 30, 1, 1));
      wr(8'h10, 32'h0000_0077, 1);
      rd(8'h04, 0, d); chk("R7 byte accepted with 2 free", d, ev(0, 31, 1, 1));
      for (int i = 0; i < 30; i++) eng_pop(b);
      eng_pop(b); chk("R5 last byte after refusal", {24'b0, b}, 32'h77);
   endtask

   task automatic t_clear;
      logic [31:0] d;
      eng_push(8'hC1);
      wr(8'h04, 32'h0000_0001, 0);
      rd(8'h04, 0, d); chk("R9 clear overflow only", d, ev(1, 0, 1, 0));
      wr(8'h04, 32'h0000_0000, 0);
      rd(8'h04, 0, d); chk("R9 zero write no effect", d, ev(1, 0, 1, 0));
      wr(8'h04, 32'hFFFF_FFFF, 0);
      rd(8'h04, 0, d); chk("R9 clear all keeps counts", d, ev(1, 0, 0, 0));
      rd(8'h14, 1, d); chk("R9 byte survives clear", d, 32'h0000_00C1);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      chk("R10 no mask no irq", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF, 0);
      rd(8'h08, 0, d); chk("R10 mask readback", d, 32'h0000_0303);
      wr(8'h08, 32'h0000_0100, 0);
      chk("R10 not-full source", {31'b0, irq}, 32'h1);
      wr(8'h08, 32'h0000_0200, 0);
      chk("R10 rx empty quiet", {31'b0, irq}, 32'h0);
      eng_push(8'hE1);
      chk("R10 rx not-empty irq", {31'b0, irq}, 32'h1);
      rd(8'h14, 1, d);
      chk("R10 irq drops after drain", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h0000_0002, 0);
      rd(8'h14, 1, d);
      chk("R10 underflow irq", {31'b0, irq}, 32'h1);
      wr(8'h04, 32'h0000_0003, 0);
      chk("R10 irq cleared", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h0, 0);
   endtask

   task automatic t_off;
      logic [31:0] d;
      logic [7:0]  b;
      wr(8'h00, 32'h0000_0403, 0);
      wr(8'h10, 32'hD1D2_D3D4, 0);
      chk("R11 tx_avail low when off", {30'b0, tx_avail, rx_room}, 32'h0);
      eng_pop(b);
      eng_push(8'h99);
      rd(8'h04, 0, d); chk("R11 handshakes ignored", d, ev(0, 4, 0, 0));
      rd(8'h00, 0, d); chk("R11 config kept", d, 32'h0000_0403);
      wr(8'h00, 32'h8000_0403, 0);
      eng_pop(b); chk("R11 resume order", {24'b0, b}, 32'hD1);
      eng_pop(b); eng_pop(b); eng_pop(b);
      rd(8'h04, 0, d); chk("R11 drained after resume", d, ev(0, 0, 0, 0));
   endtask

   task automatic t_cfg;
      logic [31:0] d;
      wr(8'h0C, 32'h4000_0007, 0);
      rd(8'h0C, 0, d); chk("R12 command readback", d, 32'h4000_0007);
      chk("R12 command pin", cfg_cmd, 32'h4000_0007);
      wr(8'h28, 32'h1234_5678, 0);
      rd(8'h28, 0, d); chk("R12 cs2 readback", d, 32'h1234_5678);
      chk("R12 cs2 pin", cfg_csmode[95:64], 32'h1234_5678);
      rd(8'h20, 0, d); chk("R12 cs0 untouched", d, 32'h0);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
   endtask

   initial begin
      #(5.0 * 100000);
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_mode();
      t_tx();
      t_rx();
      t_under();
      t_over();
      t_clear();
      t_irq();
      t_off();
      t_cfg();
      summary();
      $finish;
   end
endmodule